// File: doc/BRIEF.md
# Frame-Synced Serial Boot Transmitter

This block loads a target processor over a three-wire synchronous link made of a bit clock, a data line and a frame-sync line. It also owns the target's active-low reset and its interrupt line, and steps them through a fixed power-up order before it sends anything. A host fills a small internal word memory through a write port, sets a half-period in system clock cycles and pulses `start`. The block then walks the stored image from its third entry and sends one framed 32-bit transfer per word until it reaches the end marker.

The image after the two skipped header entries is a chain of blocks. Each block is a length word, then an address word, then as many payload words as the length gives. A length of zero ends the image. Every word is sent in the order it is stored, and so is the terminating zero. Each frame raises the frame sync for two full bit clocks before the data. The sync drops on the same falling clock edge that presents the most significant bit. Data always changes on falling edges, so a receiver can sample it on rising edges.

Top module: `boot_serial_tx`

## Requirements
- R1: After reset `tgt_rst_n`=0, `tgt_int`=0, `sclk`=0, `sfs`=0, `sdata`=0, `busy`=0 and `done`=0.
- R2: An accepted `start` holds `tgt_rst_n`=0 with `tgt_int`=0 for exactly one half-period of busy cycles. It then drives `tgt_rst_n`=1 with `tgt_int`=0 for exactly one half-period, then drives `tgt_int`=1, and only after that does a frame begin. `tgt_int` is never 1 while `tgt_rst_n` is 0.
- R3: One half-period lasts `half_cycles`+1 system clock cycles (`half_cycles` from 0 to 65535), so consecutive data bits are 2·(`half_cycles`+1) cycles apart.
- R4: `sfs` is active high. Within a frame it is high for exactly two rising edges of `sclk` before the first data bit, with `sdata` low. It falls together with a falling edge of `sclk`, the edge that presents the first data bit.
- R5: A frame carries 32 bits, most significant first. `sdata` changes only when `sclk` falls and is stable across every rising edge of `sclk`.
- R6: Outside a frame, and while `busy`=0, `sclk`, `sfs` and `sdata` are all low. No rising edge of `sclk` happens outside a frame.
- R7: Image entries 0 and 1 are never sent. The first frame carries entry 2.
- R8: From entry 2 the image is read as blocks: a length word L, an address word, then L payload words. Blocks repeat, and each word is sent as one frame in stored order.
- R9: When the frame carrying a zero length word has finished, `done`=1 and `busy`=0. No further frame follows, and `tgt_rst_n`=1 and `tgt_int`=1 stay asserted.
- R10: If the last entry (DEPTH−1) is reached before a zero length word, that entry is still sent and the run then ends as in R9.
- R11: Writes to the image and `start` pulses while `busy`=1 have no effect. The stored words and the running sequence are unchanged.
- R12: A `start` while `done`=1 begins a new run. The target goes back into reset (`tgt_rst_n`=0) and sending starts again from entry 2.
- R13: When `busy`=0, `img_we`=1 stores `img_wdata` at entry `img_waddr` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when the block is not busy |
| half_cycles | input | DIV_W | Half-period of the serial clock minus one, in clock cycles |
| img_we | input | 1 | Image write strobe |
| img_waddr | input | $clog2(DEPTH) | Image entry to write |
| img_wdata | input | WORD_W | Word to store |
| tgt_rst_n | output | 1 | Target reset, active low |
| tgt_int | output | 1 | Target interrupt line |
| sclk | output | 1 | Serial bit clock |
| sfs | output | 1 | Frame sync, active high |
| sdata | output | 1 | Serial data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run reached the end of the image |

## Verification
The bound checker covers the edge relations on every cycle. These are the rule that data and sync never move on a rising clock edge, the drop of sync on a falling edge, the low lines while idle, and the ordering of interrupt after reset release. It also checks that the lines stay released once the run is done. What the properties cannot see is the content and order of the frames. That covers the skipped header, the block walk with its zero terminator or image-end stop, the exact half-period, the pre-sync count and the ignored writes during a run. The bench's scoreboard shows these by decoding frames the way a receiver does and comparing them against a parse of its own shadow image.

// File: rtl/boot_tx_pkg.sv
// Shared types for the serial boot transmitter.
package boot_tx_pkg;

    // Run sequencer: target power-up steps, streaming, finished.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RST_HOLD,
        SQ_RST_FREE,
        SQ_IRQ_UP,
        SQ_STREAM,
        SQ_FINISHED
    } seq_t;

    // Image walker: which kind of word the pointer is on.
    typedef enum logic [1:0] {
        WK_LEN,
        WK_ADDR,
        WK_DATA
    } walk_t;

endpackage

// File: rtl/bt_half_timer.sv
// Half-period timer. While run is low it preloads the reload value.
// While run is high it counts down and pulses tick once every reload+1
// cycles. Assumes reload is held steady during a run.
module bt_half_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == '0);

    // Count down, reload on expiry or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == '0) begin
            cnt <= reload;
        end else begin
            cnt <= cnt - DIV_W'(1);
        end
    end

endmodule

// File: rtl/bt_image_ram.sv
// Image storage: one synchronous write port, one asynchronous read port.
// Assumes the caller gates writes while a run is in progress.
module bt_image_ram #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    assign rdata = mem[raddr];

    // Store a word on a write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

endmodule

// File: rtl/bt_word_walker.sv
// Image walker. Holds the pointer of the word being sent and tracks
// the block structure (length, address, payload). It flags the current
// word as the last one when it is a zero length or the final entry.
// After the last word the pointer no longer moves.
module bt_word_walker
    import boot_tx_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int DEPTH     = 16,
    parameter int HDR_WORDS = 2,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [WORD_W-1:0] word,
    output logic [AW-1:0]     ptr,
    output logic              last
);

    localparam logic [AW-1:0] FIRST_PTR = AW'(HDR_WORDS);
    localparam logic [AW-1:0] END_PTR   = AW'(DEPTH - 1);

    walk_t             mode;
    logic [WORD_W-1:0] remain;

    assign last = ((mode == WK_LEN) && (word == '0)) || (ptr == END_PTR);

    // Advance pointer and block state after each sent word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= FIRST_PTR;
            mode   <= WK_LEN;
            remain <= '0;
        end else if (restart) begin
            ptr    <= FIRST_PTR;
            mode   <= WK_LEN;
            remain <= '0;
        end else if (step && !last) begin
            ptr <= ptr + AW'(1);
            unique case (mode)
                WK_LEN: begin
                    remain <= word;
                    mode   <= WK_ADDR;
                end
                WK_ADDR: begin
                    mode <= WK_DATA;
                end
                default: begin
                    remain <= remain - WORD_W'(1);
                    if (remain == WORD_W'(1)) begin
                        mode <= WK_LEN;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/bt_frame_shifter.sv
// One framed transfer, counted in half-periods. Halves 0..2*PRE_CLKS-1
// hold the sync high. The next 2*WORD_W halves carry the bits, MSB first,
// with the clock high on odd halves. One final low half acts as the gap.
// Outputs are registered, so all three lines move together.
module bt_frame_shifter #(
    parameter int WORD_W   = 32,
    parameter int PRE_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              tick,
    output logic              active,
    output logic              frame_end,
    output logic              sclk_o,
    output logic              sfs_o,
    output logic              sdata_o
);

    localparam int PRE_H   = 2 * PRE_CLKS;
    localparam int GAP_IDX = PRE_H + 2 * WORD_W;
    localparam int KW      = $clog2(GAP_IDX + 1);

    logic [KW-1:0]     half;
    logic [WORD_W-1:0] sr;
    logic              in_pre;
    logic              in_data;

    assign in_pre    = half < KW'(PRE_H);
    assign in_data   = (half >= KW'(PRE_H)) && (half < KW'(GAP_IDX));
    assign frame_end = active && tick && (half == KW'(GAP_IDX));

    // Step the half counter and shift on each falling clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            half   <= '0;
            sr     <= '0;
        end else if (load && !active) begin
            active <= 1'b1;
            half   <= '0;
            sr     <= word;
        end else if (active && tick) begin
            if (half == KW'(GAP_IDX)) begin
                active <= 1'b0;
            end else begin
                half <= half + KW'(1);
            end
            if (half[0] && (half > KW'(PRE_H))) begin
                sr <= {sr[WORD_W-2:0], 1'b0};
            end
        end
    end

    // Register the decoded line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_o  <= 1'b0;
            sfs_o   <= 1'b0;
            sdata_o <= 1'b0;
        end else begin
            sclk_o  <= active && half[0];
            sfs_o   <= active && in_pre;
            sdata_o <= active && in_data && sr[WORD_W-1];
        end
    end

endmodule

// File: rtl/boot_serial_tx.sv
// Serial boot transmitter top. It steps the target through its reset and
// interrupt order, then streams image words from entry HDR_WORDS onward as
// framed transfers until a zero length word or the last entry is sent.
// Assumes half_cycles stays steady during a run.
module boot_serial_tx
    import boot_tx_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int DEPTH     = 16,
    parameter int DIV_W     = 16,
    parameter int PRE_CLKS  = 2,
    parameter int HDR_WORDS = 2,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  half_cycles,
    input  logic              img_we,
    input  logic [AW-1:0]     img_waddr,
    input  logic [WORD_W-1:0] img_wdata,
    output logic              tgt_rst_n,
    output logic              tgt_int,
    output logic              sclk,
    output logic              sfs,
    output logic              sdata,
    output logic              busy,
    output logic              done
);

    seq_t              state;
    seq_t              state_nx;
    logic              tick;
    logic              accept;
    logic              sh_active;
    logic              sh_end;
    logic              is_last;
    logic [AW-1:0]     rd_ptr;
    logic [WORD_W-1:0] rd_word;

    assign busy      = (state != SQ_IDLE) && (state != SQ_FINISHED);
    assign done      = (state == SQ_FINISHED);
    assign accept    = start && !busy;
    assign tgt_rst_n = (state == SQ_RST_FREE) || (state == SQ_IRQ_UP) ||
                       (state == SQ_STREAM)   || (state == SQ_FINISHED);
    assign tgt_int   = (state == SQ_IRQ_UP) || (state == SQ_STREAM) ||
                       (state == SQ_FINISHED);

    bt_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .reload (half_cycles),
        .tick   (tick)
    );

    bt_image_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (img_we && !busy),
        .waddr (img_waddr),
        .wdata (img_wdata),
        .raddr (rd_ptr),
        .rdata (rd_word)
    );

    bt_word_walker #(
        .WORD_W(WORD_W), .DEPTH(DEPTH), .HDR_WORDS(HDR_WORDS)
    ) u_walker (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .step    (sh_end),
        .word    (rd_word),
        .ptr     (rd_ptr),
        .last    (is_last)
    );

    bt_frame_shifter #(.WORD_W(WORD_W), .PRE_CLKS(PRE_CLKS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      ((state == SQ_STREAM) && !sh_active),
        .word      (rd_word),
        .tick      (tick),
        .active    (sh_active),
        .frame_end (sh_end),
        .sclk_o    (sclk),
        .sfs_o     (sfs),
        .sdata_o   (sdata)
    );

    // Choose the next run step.
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE, SQ_FINISHED: if (start)           state_nx = SQ_RST_HOLD;
            SQ_RST_HOLD:          if (tick)            state_nx = SQ_RST_FREE;
            SQ_RST_FREE:          if (tick)            state_nx = SQ_IRQ_UP;
            SQ_IRQ_UP:            if (tick)            state_nx = SQ_STREAM;
            SQ_STREAM:            if (sh_end && is_last) state_nx = SQ_FINISHED;
            default:                                   state_nx = SQ_IDLE;
        endcase
    end

    // Hold the run step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else begin
            state <= state_nx;
        end
    end

endmodule

// File: rtl/boot_serial_tx_chk.sv
// Cycle checks on the transmitter's ports, bound to every instance.
module boot_serial_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tgt_rst_n,
    input logic tgt_int,
    input logic sclk,
    input logic sfs,
    input logic sdata,
    input logic busy,
    input logic done
);

    AST_INT_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_int |-> tgt_rst_n); // R2
    AST_FRAME_AFTER_INT: assert property (@(posedge clk) disable iff (!rst_n)
        sfs |-> (tgt_int && busy)); // R2
    AST_SYNC_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sfs |-> !sdata); // R4
    AST_SYNC_DROPS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sfs) |-> $fell(sclk)); // R4
    AST_RISE_KEEPS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> ($stable(sdata) && $stable(sfs))); // R5
    AST_PARK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !sfs && !sdata)); // R6
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && tgt_rst_n && tgt_int)); // R9

endmodule

bind boot_serial_tx boot_serial_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_rst_n (tgt_rst_n),
    .tgt_int   (tgt_int),
    .sclk      (sclk),
    .sfs       (sfs),
    .sdata     (sdata),
    .busy      (busy),
    .done      (done)
);

// File: tb/boot_serial_tx_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver parses a shadow image into expected frames,
// and a receiver-style monitor decodes frames and compares them.
module boot_serial_tx_bench;

    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] half_cycles = 16'd3;
    logic        img_we = 1'b0;
    logic [AW-1:0] img_waddr = '0;
    logic [31:0] img_wdata = '0;
    logic tgt_rst_n, tgt_int, sclk, sfs, sdata, busy, done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int frames = 0;
    logic [31:0] shadow [DEPTH];
    logic [31:0] exp_q [$];

    always #10 clk = ~clk;

    boot_serial_tx u_boot_serial_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .half_cycles(half_cycles),
        .img_we(img_we), .img_waddr(img_waddr), .img_wdata(img_wdata),
        .tgt_rst_n(tgt_rst_n), .tgt_int(tgt_int), .sclk(sclk), .sfs(sfs),
        .sdata(sdata), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Receiver-style monitor sampling between clock edges.
    logic prev_sclk = 1'b0, prev_sdata = 1'b0, prev_rst = 1'b0, prev_int = 1'b0;
    bit in_frame = 0;
    int pre_cnt = 0, nbits = 0, rise1 = 0, rst_low = 0, int_wait = 0, edge_bad = 0;
    logic [31:0] cap = '0;
    logic [31:0] want;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sdata !== prev_sdata && !(prev_sclk && !sclk)) edge_bad++;
            if (sclk && !prev_sclk) begin
                if (sfs) begin
                    pre_cnt++; in_frame = 1; nbits = 0;
                end else if (in_frame) begin
                    cap = {cap[30:0], sdata};
                    nbits++;
                    if (nbits == 1) rise1 = cyc;
                    if (nbits == 2)
                        chk(cyc - rise1 == 2 * (half_cycles + 1), "R3 bit spacing",
                            cyc - rise1, 2 * (half_cycles + 1));
                    if (nbits == 32) begin
                        if (exp_q.size() == 0) chk(0, "R9 unexpected frame", cap, 0);
                        else begin
                            want = exp_q.pop_front();
                            chk(cap == want, "R5 R7 R8 frame word", cap, want);
                        end
                        chk(pre_cnt == 2, "R4 sync clocks", pre_cnt, 2);
                        in_frame = 0; pre_cnt = 0; frames++;
                    end
                end else begin
                    chk(0, "R6 stray clock", 1, 0);
                end
            end
            if (!busy) begin
                rst_low = 0; int_wait = 0;
            end else if (!tgt_rst_n) rst_low++;
            else if (!tgt_int) int_wait++;
            if (tgt_rst_n && !prev_rst) chk(!tgt_int, "R2 int low at release", tgt_int, 0);
            if (tgt_int && !prev_int) begin
                chk(rst_low == half_cycles + 1, "R2 reset hold", rst_low, half_cycles + 1);
                chk(int_wait == half_cycles + 1, "R2 release wait", int_wait, half_cycles + 1);
                chk(!sfs && !in_frame, "R2 no frame before int", sfs, 0);
            end
        end
        prev_sclk = sclk; prev_sdata = sdata; prev_rst = tgt_rst_n; prev_int = tgt_int;
    end

    task automatic write_word(input int a, input logic [31:0] d, input bit track);
        @(negedge clk);
        img_we = 1'b1; img_waddr = AW'(a); img_wdata = d;
        if (track) shadow[a] = d;
        @(negedge clk);
        img_we = 1'b0;
    endtask

    // Parse the shadow image into expected frames (R7 R8 R10).
    task automatic push_expected();
        int p = 2; int mode = 0; logic [31:0] rem = 0; bit stop = 0;
        while (!stop) begin
            exp_q.push_back(shadow[p]);
            if ((mode == 0 && shadow[p] == 0) || p == DEPTH - 1) stop = 1;
            else begin
                if (mode == 0) begin rem = shadow[p]; mode = 1; end
                else if (mode == 1) mode = 2;
                else begin rem = rem - 1; if (rem == 0) mode = 0; end
                p++;
            end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic finish_run(input int n_exp, input int f0);
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(done && !busy, "R9 done flag", {done, busy}, 2'b10);
        chk(tgt_rst_n && tgt_int, "R9 target released", {tgt_rst_n, tgt_int}, 2'b11);
        chk(frames - f0 == n_exp, "R9 frame count", frames - f0, n_exp);
        chk(exp_q.size() == 0, "R8 frames missing", exp_q.size(), 0);
        chk(!sclk && !sfs && !sdata, "R6 parked lines", {sclk, sfs, sdata}, 0);
        chk(edge_bad == 0, "R5 data moved off falling edge", edge_bad, 0);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        chk(0, "watchdog", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int f0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!tgt_rst_n && !tgt_int, "R1 target lines", {tgt_rst_n, tgt_int}, 0);
        chk(!sclk && !sfs && !sdata, "R1 serial lines", {sclk, sfs, sdata}, 0);
        chk(!busy && !done, "R1 status", {busy, done}, 0);

        // Run 1: one block, zero terminator; writes via R13
        write_word(0, 32'h8, 1); write_word(1, 32'h10f8, 1);
        write_word(2, 32'd2, 1); write_word(3, 32'h0080_9802, 1);
        write_word(4, 32'hDEAD_BEEF, 1); write_word(5, 32'h8000_0001, 1);
        write_word(6, 32'h0, 1);
        for (int i = 7; i < DEPTH; i++) write_word(i, 32'h5555_5555, 1);
        half_cycles = 16'd3;
        push_expected(); f0 = frames;
        pulse_start();
        while (frames - f0 < 1) @(negedge clk);
        // R11: write and start during a run are ignored
        write_word(5, 32'h1234_5678, 0);
        pulse_start();
        @(negedge clk);
        chk(tgt_rst_n && busy, "R11 start ignored while busy", {tgt_rst_n, busy}, 2'b11);
        finish_run(5, f0);

        // Run 2: restart from done, image without terminator, fastest rate
        for (int i = 2; i < DEPTH; i++) write_word(i, 32'hA500_0000 + 32'(i * 7), 1);
        write_word(2, 32'd20, 1);
        half_cycles = 16'd0;
        push_expected(); f0 = frames;
        pulse_start();
        chk(!tgt_rst_n && busy, "R12 target reset again", {tgt_rst_n, busy}, 2'b01);
        finish_run(DEPTH - 2, f0); // R10

        // Run 3: two blocks then terminator
        write_word(2, 32'd1, 1); write_word(3, 32'h100, 1); write_word(4, 32'hF0F0_0F0F, 1);
        write_word(5, 32'd2, 1); write_word(6, 32'h200, 1); write_word(7, 32'h0000_0001, 1);
        write_word(8, 32'hFFFF_FFFE, 1); write_word(9, 32'h0, 1);
        half_cycles = 16'd1;
        push_expected(); f0 = frames;
        pulse_start();
        finish_run(8, f0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule